// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the bus-facing part of a byte-wide, 8192-location non-volatile memory that is reached over a two-wire serial bus. It samples the clock and data lines with the system clock and recognises start and stop conditions. It takes in a device select word, checks it against the memory type code and three strap inputs, and takes a two-byte word address. It then serves single-byte writes, page writes, reads from the current address and sequential reads. It drives the data line only through an active-low output enable, so the pad is open-drain. Write bytes go one by one to a separate page-program unit, and a commit pulse is raised when a stop ends a write. While that unit reports busy, the block does not acknowledge its device select word, so a host can poll for completion. Read data comes from a synchronous memory port that is addressed by the internal address counter. That counter is shared by reads and writes and is kept between transactions.

The control state machine has twelve states. `ST_IDLE` waits for a start. `ST_DEVADR` shifts in the device select word. Then `ST_DEVACK` (match, to acknowledge) is entered, or on a mismatch or busy the machine returns to `ST_IDLE`. On a write the path runs `ST_ADRHI` → `ST_HIACK` → `ST_ADRLO` → `ST_LOACK` → `ST_WDATA`, and then loops between `ST_WDATA` and `ST_WDACK` for each data byte. On a read the path runs `ST_DEVACK` → `ST_RDATA` → `ST_RDACK`. A host acknowledge leads back to `ST_RDATA`, and a host no-acknowledge leads to `ST_DRAIN`, which holds the line released. A start from any state leads to `ST_DEVADR` and a stop from any state leads to `ST_IDLE`. The start takes priority. Each bit move happens on a rising or falling edge of the synchronised clock line.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the output enable is released (`sda_oe_n` = 1), `wr_en` and `prog_start` are low, and the address counter is 0.
- R2: The device select word is accepted only when bits 7:4 equal 1010 and bits 3:1 equal `strap_i`. Bit 0 is 1 for read and 0 for write. A mismatch gives no acknowledge in the 9th clock, and all later bytes are ignored until the next start: no acknowledge, no data driven, no write.
- R3: A write select is followed by two word-address bytes, high byte first, and each is acknowledged. Only the low 13 bits are kept: the low 5 bits of the high byte and all of the low byte.
- R4: Each write data byte is acknowledged and produces one `wr_en` pulse, with `wr_addr` equal to the counter and `wr_data` equal to the byte. A stop that follows at least one data byte produces a single `prog_start` pulse.
- R5: During a write the counter steps only its low 5 bits and wraps within the 32-byte page. The upper 8 bits never change.
- R6: While `prog_busy` is high, a device select word is not acknowledged, even when it matches.
- R7: A read with no preceding address returns the byte at the counter, which holds the last accessed address plus one. The counter then advances by one.
- R8: In a read, a host acknowledge makes the block send the byte at the next address, with the counter wrapping from 8191 to 0. A host no-acknowledge makes the block release the line until the next start or stop.
- R9: A repeated start keeps the counter, so an address-only write followed by a read returns data from that address.
- R10: The output enable changes only while the clock line is low, and never during a stable high clock phase.
- R11: Read bits go out MSB first. A 0 bit pulls the line low and a 1 bit releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_n | output | 1 | Data line pull-down enable, active low |
| strap_i | input | 3 | Device select strap value |
| prog_busy | input | 1 | Page-program unit busy |
| wr_en | output | 1 | One-cycle write byte strobe |
| wr_addr | output | 13 | Write byte address |
| wr_data | output | 8 | Write byte value |
| prog_start | output | 1 | One-cycle commit pulse after a write stop |
| mem_rd_addr | output | 13 | Synchronous memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after address |

## Verification
The bench sends device select words with the wrong type code, with the wrong strap value, and with a correct match. This separates rejection, and the silence after it, from a normal acknowledge. It sets word addresses with stray upper bits, with page offsets near 31, and near the top of the array. These show whether the 13-bit truncation, the in-page wrap on writes and the full-array wrap on reads are each done in the right place. It checks reads with no preceding address after writes, after reads and after rejected traffic, which shows whether the counter is shared and kept. It polls during and after a program cycle to tell a busy refusal from a ready acknowledge.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_ADRHI,
        ST_HIACK,
        ST_ADRLO,
        ST_LOACK,
        ST_WDATA,
        ST_WDACK,
        ST_RDATA,
        ST_RDACK,
        ST_DRAIN
    } tw_state_e;

endpackage

// File: rtl/tw_line_sync.sv
// Multi-stage synchroniser for one bus line; also keeps the previous
// synchronised sample so that edges can be detected downstream.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic prev_o
);

    logic [STAGES-1:0] pipe_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
            last_q <= 1'b1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], line_i};
            last_q <= pipe_q[STAGES-1];
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign prev_o  = last_q;

endmodule

// File: rtl/tw_bus_cond.sv
// Start/stop detection: a data edge while the clock is steadily high.
module tw_bus_cond (
    input  logic scl_lvl,
    input  logic scl_prev,
    input  logic sda_lvl,
    input  logic sda_prev,
    output logic start_o,
    output logic stop_o
);

    logic scl_steady_hi;

    assign scl_steady_hi = scl_lvl & scl_prev;
    assign start_o       = scl_steady_hi & sda_prev & ~sda_lvl;
    assign stop_o        = scl_steady_hi & ~sda_prev & sda_lvl;

endmodule

// File: rtl/tw_addr_ctr.sv
// Shared word-address counter: parallel load, in-page step, linear step.
module tw_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_page_i,
    input  logic              inc_full_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [PAGE_W-1:0] PG_ONE  = {{(PAGE_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] LIN_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0] pg_next;

    assign pg_next = addr_q[PAGE_W-1:0] + PG_ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_val_i;
        end else if (inc_page_i) begin
            addr_q <= {addr_q[ADDR_W-1:PAGE_W], pg_next};
        end else if (inc_full_i) begin
            addr_q <= addr_q + LIN_ONE;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_n,
    input  logic [2:0]        strap_i,
    input  logic              prog_busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              prog_start,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data
);

    localparam int          ADDR_HI_W = ADDR_W - 8;
    localparam logic [3:0]  BITS_FULL = 4'd8;
    localparam logic [3:0]  BITS_LAST = 4'd7;

    // ---------------------------------------------------------------
    // Line sampling and bus conditions
    // ---------------------------------------------------------------
    logic scl_lvl, scl_prev, sda_lvl, sda_prev;
    logic scl_rise, scl_fall;
    logic start_det, stop_det;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (scl_i),
        .level_o (scl_lvl),
        .prev_o  (scl_prev)
    );

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (sda_i),
        .level_o (sda_lvl),
        .prev_o  (sda_prev)
    );

    tw_bus_cond u_cond (
        .scl_lvl  (scl_lvl),
        .scl_prev (scl_prev),
        .sda_lvl  (sda_lvl),
        .sda_prev (sda_prev),
        .start_o  (start_det),
        .stop_o   (stop_det)
    );

    assign scl_rise = scl_lvl & ~scl_prev;
    assign scl_fall = ~scl_lvl & scl_prev;

    // ---------------------------------------------------------------
    // State and datapath registers
    // ---------------------------------------------------------------
    tw_state_e              state_q, state_d;
    logic [3:0]             bit_cnt_q;
    logic [7:0]             shreg_q;
    logic [7:0]             tx_q;
    logic                   rw_q;
    logic                   host_ack_q;
    logic [ADDR_HI_W-1:0]   hi_q;
    logic                   wr_pend_q;
    logic                   wr_en_q;
    logic [ADDR_W-1:0]      wr_addr_q;
    logic [7:0]             wr_data_q;
    logic                   prog_start_q;

    logic                   byte_full;
    logic                   addr_ok;
    logic                   step_ok;
    logic                   ctr_load, ctr_inc_page, ctr_inc_full;
    logic [ADDR_W-1:0]      ctr_addr;

    assign byte_full = (bit_cnt_q == BITS_FULL);
    assign addr_ok   = (shreg_q[7:4] == DEV_TYPE) &&
                       (shreg_q[3:1] == strap_i) && !prog_busy;
    assign step_ok   = !start_det && !stop_det;

    // ---------------------------------------------------------------
    // Address counter control
    // ---------------------------------------------------------------
    assign ctr_load     = step_ok && (state_q == ST_ADRLO) && scl_fall && byte_full;
    assign ctr_inc_page = step_ok && (state_q == ST_WDATA) && scl_fall && byte_full;
    assign ctr_inc_full = step_ok && scl_fall &&
                          (((state_q == ST_DEVACK) && rw_q) ||
                           ((state_q == ST_RDACK) && host_ack_q));

    tw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i ({hi_q, shreg_q}),
        .inc_page_i (ctr_inc_page),
        .inc_full_i (ctr_inc_full),
        .addr_o     (ctr_addr)
    );

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEVADR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_DEVADR: if (scl_fall && byte_full)
                               state_d = addr_ok ? ST_DEVACK : ST_IDLE;
                ST_DEVACK: if (scl_fall)
                               state_d = rw_q ? ST_RDATA : ST_ADRHI;
                ST_ADRHI:  if (scl_fall && byte_full) state_d = ST_HIACK;
                ST_HIACK:  if (scl_fall) state_d = ST_ADRLO;
                ST_ADRLO:  if (scl_fall && byte_full) state_d = ST_LOACK;
                ST_LOACK:  if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:  if (scl_fall && byte_full) state_d = ST_WDACK;
                ST_WDACK:  if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:  if (scl_fall && (bit_cnt_q == BITS_LAST))
                               state_d = ST_RDACK;
                ST_RDACK:  if (scl_fall)
                               state_d = host_ack_q ? ST_RDATA : ST_DRAIN;
                ST_DRAIN:  state_d = ST_DRAIN;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Datapath: shifting, bit counting, write hand-off, read loads
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q    <= '0;
            shreg_q      <= '0;
            tx_q         <= '1;
            rw_q         <= 1'b0;
            host_ack_q   <= 1'b0;
            hi_q         <= '0;
            wr_pend_q    <= 1'b0;
            wr_en_q      <= 1'b0;
            wr_addr_q    <= '0;
            wr_data_q    <= '0;
            prog_start_q <= 1'b0;
        end else begin
            wr_en_q      <= 1'b0;
            prog_start_q <= 1'b0;
            if (start_det) begin
                bit_cnt_q <= '0;
            end else if (stop_det) begin
                bit_cnt_q    <= '0;
                prog_start_q <= wr_pend_q;
                wr_pend_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_DEVADR, ST_ADRHI, ST_ADRLO, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg_q   <= {shreg_q[6:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall && byte_full) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_DEVADR) rw_q <= shreg_q[0];
                            if (state_q == ST_ADRHI)  hi_q <= shreg_q[ADDR_HI_W-1:0];
                            if (state_q == ST_WDATA) begin
                                wr_en_q   <= 1'b1;
                                wr_addr_q <= ctr_addr;
                                wr_data_q <= shreg_q;
                                wr_pend_q <= 1'b1;
                            end
                        end
                    end
                    ST_DEVACK: begin
                        if (scl_fall && rw_q) begin
                            tx_q      <= mem_rd_data;
                            bit_cnt_q <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt_q == BITS_LAST) begin
                                bit_cnt_q <= '0;
                            end else begin
                                tx_q      <= {tx_q[6:0], 1'b1};
                                bit_cnt_q <= bit_cnt_q + 4'd1;
                            end
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) begin
                            host_ack_q <= ~sda_lvl;
                        end else if (scl_fall && host_ack_q) begin
                            tx_q <= mem_rd_data;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------------------------------------------------------
    // Output logic
    // ---------------------------------------------------------------
    always_comb begin
        unique case (state_q)
            ST_DEVACK, ST_HIACK, ST_LOACK, ST_WDACK: sda_oe_n = 1'b0;
            ST_RDATA:                                sda_oe_n = tx_q[7];
            default:                                 sda_oe_n = 1'b1;
        endcase
    end

    assign wr_en       = wr_en_q;
    assign wr_addr     = wr_addr_q;
    assign wr_data     = wr_data_q;
    assign prog_start  = prog_start_q;
    assign mem_rd_addr = ctr_addr;

endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input tw_state_e         state_q,
    input logic              prog_busy,
    input logic              wr_en,
    input logic              prog_start,
    input logic              sda_oe_n,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] ctr_addr
);

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEVACK && $past(state_q) == ST_DEVADR) |-> !$past(prog_busy)); // R6

    AST_OE_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_lvl) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_n)); // R10

    AST_WRITE_STROBE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state_q == ST_WDACK)); // R4

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (state_q == ST_IDLE && !wr_en)); // R4

    AST_PAGE_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ctr_addr[ADDR_W-1:PAGE_W] == wr_addr[ADDR_W-1:PAGE_W])); // R5

endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .prog_busy  (prog_busy),
    .wr_en      (wr_en),
    .prog_start (prog_start),
    .sda_oe_n   (sda_oe_n),
    .scl_lvl    (scl_lvl),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .wr_addr    (wr_addr),
    .ctr_addr   (ctr_addr)
);

// File: tb/tw_eeprom_slave_test.sv
module tw_eeprom_slave_test;

    localparam int         H        = 40;
    localparam int         BUSY_CYC = 3000;
    localparam int         DEPTH    = 8192;
    localparam logic [2:0] STRAP    = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_h = 1'b1;
    logic        sda_h = 1'b1;
    logic        sda_bus;
    logic        sda_oe_n;
    logic        prog_busy;
    logic        wr_en;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        prog_start;
    logic [12:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int busy_cnt = 0;
    int n_commit = 0;
    int hi_run = 0;
    bit prev_oe = 1'b1;
    bit finished = 1'b0;

    logic [7:0]  phys    [int];
    logic [7:0]  ref_mem [int];
    logic [20:0] pend    [$];
    logic [20:0] wr_log  [$];
    int          ref_ctr = 0;

    always #4 clk = ~clk;

    assign sda_bus   = sda_h & sda_oe_n;
    assign prog_busy = (busy_cnt != 0);

    tw_eeprom_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_h),
        .sda_i       (sda_bus),
        .sda_oe_n    (sda_oe_n),
        .strap_i     (STRAP),
        .prog_busy   (prog_busy),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .prog_start  (prog_start),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    function automatic logic [7:0] init_byte(input int a);
        logic [7:0] v;
        v = 8'(a * 29) ^ 8'(a >> 5) ^ 8'h3C;
        return v;
    endfunction

    function automatic logic [7:0] phys_rd(input int a);
        if (phys.exists(a)) return phys[a];
        return init_byte(a);
    endfunction

    function automatic logic [7:0] ref_rd(input int a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return init_byte(a);
    endfunction

    // Memory and page-program unit model
    always @(posedge clk) begin
        mem_rd_data <= phys_rd(int'(mem_rd_addr));
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (wr_en) begin
            pend.push_back({wr_addr, wr_data});
            wr_log.push_back({wr_addr, wr_data});
        end
        if (prog_start) begin
            foreach (pend[i]) phys[int'(pend[i][20:8])] = pend[i][7:0];
            pend.delete();
            busy_cnt <= BUSY_CYC;
            n_commit <= n_commit + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Output timing monitor, every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_h) hi_run++;
            else hi_run = 0;
            if (hi_run >= 4)
                chk(sda_oe_n == prev_oe, "R10 oe moved in clock-high phase",
                    int'(sda_oe_n), int'(prev_oe));
            prev_oe = sda_oe_n;
        end
    end

    task automatic hold();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hold();
        scl_h = 1'b1; hold();
        sda_h = 1'b0; hold();
        scl_h = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hold();
        scl_h = 1'b1; hold();
        sda_h = 1'b1; hold();
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; hold();
            scl_h = 1'b1; hold();
            scl_h = 1'b0;
        end
        sda_h = 1'b1; hold();
        scl_h = 1'b1;
        repeat (H / 2) @(negedge clk);
        acked = (sda_bus == 1'b0);
        repeat (H / 2) @(negedge clk);
        scl_h = 1'b0;
    endtask

    task automatic get_byte(input bit host_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; hold();
            scl_h = 1'b1;
            repeat (H / 2) @(negedge clk);
            b[i] = sda_bus;
            repeat (H / 2) @(negedge clk);
            scl_h = 1'b0;
        end
        sda_h = host_ack ? 1'b0 : 1'b1; hold();
        scl_h = 1'b1; hold();
        scl_h = 1'b0;
    endtask

    function automatic logic [7:0] dev_word(input bit rd);
        return {4'b1010, STRAP, rd};
    endfunction

    // Address-only write; leaves the bus after the low address byte
    task automatic set_addr(input logic [15:0] wa, input string req);
        bit a;
        bus_start();
        put_byte(dev_word(1'b0), a); chk(a, {req, " select ack"}, int'(a), 1);
        put_byte(wa[15:8], a);       chk(a, "R3 high address ack", int'(a), 1);
        put_byte(wa[7:0], a);        chk(a, "R3 low address ack", int'(a), 1);
        ref_ctr = int'(wa[12:0]);
    endtask

    task automatic read_run(input int n, input string req);
        logic [7:0] b;
        logic [7:0] e;
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            e = ref_rd(ref_ctr);
            chk(b == e, req, int'(b), int'(e));
            ref_ctr = (ref_ctr + 1) % DEPTH;
        end
    endtask

    task automatic wait_ready(output int polls);
        bit a;
        polls = 0;
        a = 1'b0;
        while (!a && polls < 40) begin
            bus_start();
            put_byte(dev_word(1'b0), a);
            bus_stop();
            polls++;
        end
        chk(a, "R6 ack returns after program", int'(a), 1);
    endtask

    initial begin
        bit         a;
        int         polls;
        int         base_log;
        logic [7:0] b;
        logic [12:0] ea;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1: reset state
        chk(sda_oe_n == 1'b1, "R1 oe released", int'(sda_oe_n), 1);
        chk(wr_en == 1'b0, "R1 no write strobe", int'(wr_en), 0);
        chk(prog_start == 1'b0, "R1 no commit", int'(prog_start), 0);

        // R2: wrong type code, then further bytes ignored
        bus_start();
        put_byte({4'b1011, STRAP, 1'b0}, a); chk(!a, "R2 type mismatch nack", int'(a), 0);
        put_byte(8'h00, a);                  chk(!a, "R2 ignored byte nack", int'(a), 0);
        put_byte(8'h55, a);                  chk(!a, "R2 ignored data nack", int'(a), 0);
        bus_stop();
        repeat (10) @(negedge clk);
        chk(wr_log.size() == 0, "R2 no write after mismatch", wr_log.size(), 0);
        chk(n_commit == 0, "R2 no commit after mismatch", n_commit, 0);

        // R2: wrong strap on a read, line stays released
        bus_start();
        put_byte({4'b1010, 3'b100, 1'b1}, a); chk(!a, "R2 strap mismatch nack", int'(a), 0);
        get_byte(1'b0, b); chk(b == 8'hFF, "R2 no data after mismatch", int'(b), 8'hFF);
        bus_stop();

        // R7/R1: first read with no address uses counter 0
        bus_start();
        put_byte(dev_word(1'b1), a); chk(a, "R7 read select ack", int'(a), 1);
        read_run(1, "R7 R11 current read at 0");
        bus_stop();

        // R3/R4: byte write with stray upper address bits
        base_log = wr_log.size();
        set_addr(16'hE123, "R4");
        put_byte(8'h5A, a); chk(a, "R4 data ack", int'(a), 1);
        bus_stop();
        repeat (10) @(negedge clk);
        ref_mem[13'h0123] = 8'h5A;
        ref_ctr = 13'h0124;
        chk(wr_log.size() == base_log + 1, "R4 one write strobe", wr_log.size(), base_log + 1);
        if (wr_log.size() > base_log)
            chk(wr_log[base_log] == {13'h0123, 8'h5A}, "R3 R4 write address and data",
                int'(wr_log[base_log]), int'({13'h0123, 8'h5A}));
        chk(n_commit == 1, "R4 commit pulse", n_commit, 1);

        // R6: first poll is refused, later one accepted
        bus_start();
        put_byte(dev_word(1'b0), a); chk(!a, "R6 busy nack", int'(a), 0);
        bus_stop();
        wait_ready(polls);

        // R7: counter is last written address plus one
        bus_start();
        put_byte(dev_word(1'b1), a); chk(a, "R7 read select ack", int'(a), 1);
        read_run(1, "R7 current read after write");
        bus_stop();

        // R9: random read through repeated start
        set_addr(16'h0123, "R9");
        bus_start();
        put_byte(dev_word(1'b1), a); chk(a, "R9 read select ack after restart", int'(a), 1);
        read_run(1, "R9 random read data");
        bus_stop();

        // R5: page write crossing the page end
        base_log = wr_log.size();
        set_addr(16'h041C, "R5");
        for (int i = 0; i < 6; i++) begin
            put_byte(8'hC0 + 8'(i), a); chk(a, "R4 page data ack", int'(a), 1);
        end
        bus_stop();
        repeat (10) @(negedge clk);
        chk(wr_log.size() == base_log + 6, "R5 six strobes", wr_log.size(), base_log + 6);
        for (int i = 0; i < 6; i++) begin
            ea = {8'h20, 5'((5'h1C + i) % 32)};
            ref_mem[int'(ea)] = 8'hC0 + 8'(i);
            if (wr_log.size() > base_log + i)
                chk(wr_log[base_log + i][20:8] == ea, "R5 in-page address",
                    int'(wr_log[base_log + i][20:8]), int'(ea));
        end
        ref_ctr = 13'h0402;
        wait_ready(polls);

        // R7: counter after in-page wrap
        bus_start();
        put_byte(dev_word(1'b1), a); chk(a, "R7 read select ack", int'(a), 1);
        read_run(1, "R7 R5 read after page wrap");
        bus_stop();

        // R8: sequential read crossing the page boundary linearly
        set_addr(16'h041E, "R8");
        bus_start();
        put_byte(dev_word(1'b1), a); chk(a, "R8 read select ack", int'(a), 1);
        read_run(3, "R8 R5 sequential across page");
        bus_stop();

        // R8: wrap from top of array, then release after host nack
        set_addr(16'h1FFE, "R8");
        bus_start();
        put_byte(dev_word(1'b1), a); chk(a, "R8 read select ack", int'(a), 1);
        read_run(4, "R8 sequential wrap");
        get_byte(1'b0, b); chk(b == 8'hFF, "R8 released after host nack", int'(b), 8'hFF);
        bus_stop();

        // R7/R8: counter kept past wrap
        bus_start();
        put_byte(dev_word(1'b1), a); chk(a, "R7 read select ack", int'(a), 1);
        read_run(1, "R7 R8 current read after wrap");
        bus_stop();

        repeat (20) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule